// File: doc/BRIEF.md
# ADC Conversion Mode Sequencer

This block is the digital control sequencer for a successive-approximation analog-to-digital converter with up to sixteen input channels. It picks which channels the converter samples and in what order. It accepts a start trigger from one of three selectable sources and keeps the latest result of every channel in a 16-bit result register of its own. The analog part (sample-and-hold and comparator) sits outside. The sequencer drives it through a channel select and a one-cycle start pulse. The converter answers with a one-cycle done pulse and a 12-bit result.

Three operating modes are offered. Single mode converts one channel once. Multi mode converts a group of channels once, in ascending order. Scan mode repeats the group pass after pass for as long as the run bit stays high. A group is either four or eight channels wide. It runs from the group base, which is the configured channel with its low bits cleared, up to the configured channel, so one to four or one to eight channels are converted. At the end of every complete pass the block pulses an end-of-conversion interrupt and a transfer request.

The controller has three states:
- IDLE waits for a trigger. IDLE→LAUNCH occurs on a trigger, and the mode and channel range are latched at that point.
- LAUNCH issues the start pulse and always moves on to WAIT.
- WAIT holds until the done pulse arrives. WAIT→LAUNCH occurs for the next channel in the group, or back at the base for another scan pass. WAIT→IDLE occurs when the sequence is complete or when a scan is stopped.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the block is idle. busy, conv_start, eoc_irq and xfer_req are 0, and every result register reads 0.
- R2: Each result is stored in the register of the channel that was converted. The 12-bit value goes in bits 11:0 and bits 15:12 read as zero.
- R3: In single mode (cfg_mode = 0, and also for the unused value 3), one trigger gives exactly one conversion, of channel cfg_chan, and then the block returns to idle. conv_start is a pulse of one cycle.
- R4: In multi mode (cfg_mode = 1), the channels from base to cfg_chan are converted once each, in ascending order. The base is cfg_chan with bits 1:0 cleared when cfg_grp8 = 0, or with bits 2:0 cleared when cfg_grp8 = 1. conv_chan stays stable while a conversion is pending.
- R5: In scan mode (cfg_mode = 2), the same group is converted pass after pass, from base to cfg_chan, while start_bit stays high.
- R6: In scan mode, a low start_bit seen when a conversion finishes ends the run at that point, even partway through a pass. No further conv_start follows, and an incomplete pass raises no interrupt.
- R7: cfg_src selects the trigger source. Value 0 selects a rising edge of start_bit. Value 1 selects a high cycle of tmr_trig. Value 2 selects a falling edge of the active-low ext_trig_n, which passes through a two-flop synchronizer. The sources not selected have no effect.
- R8: A trigger that arrives while a sequence is running is ignored. It neither adds conversions nor restarts the sequence.
- R9: eoc_irq and xfer_req pulse together for one cycle, in the cycle after the done pulse of the last channel of each complete pass.
- R10: A conv_done pulse while no conversion is pending writes no result register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_mode | input | 2 | 0 single, 1 multi, 2 scan |
| cfg_grp8 | input | 1 | Group width: 0 for four channels, 1 for eight |
| cfg_chan | input | 4 | Single channel, or last channel of the group |
| cfg_src | input | 2 | Trigger source: 0 software, 1 timer, 2 external |
| start_bit | input | 1 | Run bit: its rising edge is the software trigger, and it keeps a scan running while high |
| tmr_trig | input | 1 | Timer trigger pulse |
| ext_trig_n | input | 1 | Asynchronous external trigger pin, active low |
| conv_done | input | 1 | Converter finished, one cycle |
| conv_result | input | 12 | Converter result, valid with conv_done |
| rd_chan | input | 4 | Result register read select |
| conv_start | output | 1 | Start pulse to the converter |
| conv_chan | output | 4 | Channel being converted |
| busy | output | 1 | A sequence is running |
| eoc_irq | output | 1 | End-of-pass interrupt pulse |
| xfer_req | output | 1 | End-of-pass transfer request pulse |
| rd_data | output | 16 | Result register of rd_chan |

## Verification
The hardest case to reach from the ports is a scan stopped partway through a pass. start_bit has to fall while one particular mid-group conversion is pending, and at no other time. The bench counts conversions as the converter model accepts them. It clears start_bit in the wait window of a chosen conversion: once at a pass boundary and once in the middle of a pass. It then compares the number of conversions and interrupts against that stopping point. A stray done pulse while idle is injected on a separate path beside the converter model.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    typedef enum logic [1:0] {
        MODE_SINGLE = 2'd0,
        MODE_MULTI  = 2'd1,
        MODE_SCAN   = 2'd2
    } adc_mode_e;

    typedef enum logic [1:0] {
        SRC_SW  = 2'd0,
        SRC_TMR = 2'd1,
        SRC_EXT = 2'd2
    } adc_src_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LAUNCH = 2'd1,
        ST_WAIT   = 2'd2
    } seq_state_e;
endpackage

// File: rtl/adc_trig_sel.sv
module adc_trig_sel
    import adc_seq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] src,
    input  logic       start_bit,
    input  logic       tmr_trig,
    input  logic       ext_trig_n,
    output logic       trig
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   ext_prev;
    logic                   start_prev;
    logic                   ext_fall;
    logic                   sw_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q     <= '1;
            ext_prev   <= 1'b1;
            start_prev <= 1'b0;
        end else begin
            sync_q     <= {sync_q[SYNC_STAGES-2:0], ext_trig_n};
            ext_prev   <= sync_q[SYNC_STAGES-1];
            start_prev <= start_bit;
        end
    end

    assign ext_fall = ext_prev & ~sync_q[SYNC_STAGES-1];
    assign sw_rise  = start_bit & ~start_prev;

    always_comb begin
        unique case (src)
            SRC_SW:  trig = sw_rise;
            SRC_TMR: trig = tmr_trig;
            SRC_EXT: trig = ext_fall;
            default: trig = 1'b0;
        endcase
    end

    // R7: the synchronized edge detector yields single-cycle pulses
    assert_ext_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ext_fall |=> !ext_fall);
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
    parameter int NUM_CH = 16,
    parameter int RES_W  = 12,
    parameter int REG_W  = 16,
    localparam int CH_W  = $clog2(NUM_CH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CH_W-1:0]  wr_chan,
    input  logic [RES_W-1:0] wr_data,
    input  logic [CH_W-1:0]  rd_chan,
    output logic [REG_W-1:0] rd_data
);
    logic [REG_W-1:0] regs [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs[g] <= '0;
            end else if (wr_en && (wr_chan == CH_W'(g))) begin
                regs[g] <= REG_W'(wr_data);
            end
        end
    end

    assign rd_data = regs[rd_chan];
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
    import adc_seq_pkg::*;
#(
    parameter int CH_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trig,
    input  logic            start_bit,
    input  logic [1:0]      mode,
    input  logic            grp8,
    input  logic [CH_W-1:0] cfg_chan,
    input  logic            conv_done,
    output logic            conv_start,
    output logic [CH_W-1:0] conv_chan,
    output logic            busy,
    output logic            wr_en,
    output logic            eoc_pulse
);
    localparam logic [CH_W-1:0] MASK4 = CH_W'(3);
    localparam logic [CH_W-1:0] MASK8 = CH_W'(7);

    seq_state_e      state, state_nx;
    logic [CH_W-1:0] cur_ch, base_ch, last_ch, grp_base;
    logic            run_scan, is_last, grouped, eoc_q;

    assign grp_base = cfg_chan & ~(grp8 ? MASK8 : MASK4);
    assign grouped  = (mode == MODE_MULTI) || (mode == MODE_SCAN);
    assign is_last  = (cur_ch == last_ch);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (trig) state_nx = ST_LAUNCH;
            ST_LAUNCH: state_nx = ST_WAIT;
            ST_WAIT: begin
                if (conv_done) begin
                    if (run_scan && !start_bit) state_nx = ST_IDLE;
                    else if (!is_last)          state_nx = ST_LAUNCH;
                    else if (run_scan)          state_nx = ST_LAUNCH;
                    else                        state_nx = ST_IDLE;
                end
            end
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_ch   <= '0;
            base_ch  <= '0;
            last_ch  <= '0;
            run_scan <= 1'b0;
            eoc_q    <= 1'b0;
        end else begin
            eoc_q <= (state == ST_WAIT) && conv_done && is_last;
            if (state == ST_IDLE && trig) begin
                run_scan <= (mode == MODE_SCAN);
                last_ch  <= cfg_chan;
                cur_ch   <= grouped ? grp_base : cfg_chan;
                base_ch  <= grouped ? grp_base : cfg_chan;
            end else if (state == ST_WAIT && conv_done && state_nx == ST_LAUNCH) begin
                cur_ch <= is_last ? base_ch : cur_ch + 1'b1;
            end
        end
    end

    always_comb begin
        conv_start = (state == ST_LAUNCH);
        busy       = (state != ST_IDLE);
        wr_en      = (state == ST_WAIT) && conv_done;
        conv_chan  = cur_ch;
        eoc_pulse  = eoc_q;
    end

    assert_start_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);
    assert_chan_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !conv_start) |-> $stable(conv_chan));
    assert_start_by_trigger_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(trig));
    assert_eoc_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_pulse |-> $past(conv_done));
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
    parameter int NUM_CH      = 16,
    parameter int RES_W       = 12,
    parameter int REG_W       = 16,
    parameter int SYNC_STAGES = 2,
    localparam int CH_W       = $clog2(NUM_CH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       cfg_mode,
    input  logic             cfg_grp8,
    input  logic [CH_W-1:0]  cfg_chan,
    input  logic [1:0]       cfg_src,
    input  logic             start_bit,
    input  logic             tmr_trig,
    input  logic             ext_trig_n,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_result,
    input  logic [CH_W-1:0]  rd_chan,
    output logic             conv_start,
    output logic [CH_W-1:0]  conv_chan,
    output logic             busy,
    output logic             eoc_irq,
    output logic             xfer_req,
    output logic [REG_W-1:0] rd_data
);
    logic trig, wr_en, eoc_pulse;

    adc_trig_sel #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
        .clk(clk), .rst_n(rst_n), .src(cfg_src), .start_bit(start_bit),
        .tmr_trig(tmr_trig), .ext_trig_n(ext_trig_n), .trig(trig)
    );

    adc_seq_fsm #(.CH_W(CH_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .trig(trig), .start_bit(start_bit),
        .mode(cfg_mode), .grp8(cfg_grp8), .cfg_chan(cfg_chan),
        .conv_done(conv_done), .conv_start(conv_start), .conv_chan(conv_chan),
        .busy(busy), .wr_en(wr_en), .eoc_pulse(eoc_pulse)
    );

    adc_result_bank #(.NUM_CH(NUM_CH), .RES_W(RES_W), .REG_W(REG_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_chan(conv_chan),
        .wr_data(conv_result), .rd_chan(rd_chan), .rd_data(rd_data)
    );

    assign eoc_irq  = eoc_pulse;
    assign xfer_req = eoc_pulse;
endmodule

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;
    localparam int LAT = 3;

    logic        clk = 0;
    logic        rst_n = 0;
    logic [1:0]  cfg_mode = 0;
    logic        cfg_grp8 = 0;
    logic [3:0]  cfg_chan = 0;
    logic [1:0]  cfg_src = 0;
    logic        start_bit = 0;
    logic        tmr_trig = 0;
    logic        ext_trig_n = 1;
    logic [3:0]  rd_chan = 0;
    logic        stray_done = 0;
    logic [11:0] stray_res = 0;
    logic        mdl_done = 0;
    logic [11:0] mdl_res = 0;
    logic        conv_done;
    logic [11:0] conv_result;
    logic        conv_start, busy, eoc_irq, xfer_req;
    logic [3:0]  conv_chan;
    logic [15:0] rd_data;

    assign conv_done   = mdl_done | stray_done;
    assign conv_result = stray_done ? stray_res : mdl_res;

    always #5 clk = ~clk;

    adc_seq_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_grp8(cfg_grp8),
        .cfg_chan(cfg_chan), .cfg_src(cfg_src), .start_bit(start_bit),
        .tmr_trig(tmr_trig), .ext_trig_n(ext_trig_n), .conv_done(conv_done),
        .conv_result(conv_result), .rd_chan(rd_chan), .conv_start(conv_start),
        .conv_chan(conv_chan), .busy(busy), .eoc_irq(eoc_irq),
        .xfer_req(xfer_req), .rd_data(rd_data)
    );

    int n_chk = 0;
    int n_fail = 0;
    int n_conv = 0;
    int n_irq = 0;
    int n_xfer = 0;
    logic [3:0]  seq_log [256];
    logic [11:0] exp_res [16] = '{default: 12'd0};
    logic        pend = 0;
    int          dly = 0;
    logic [3:0]  pch = 0;

    function automatic logic [11:0] fres(int ch, int n);
        return 12'((ch * 251 + n * 37 + 9) % 4096);
    endfunction

    // converter model and event counters
    always @(posedge clk) begin
        mdl_done <= 1'b0;
        if (eoc_irq)  n_irq  <= n_irq + 1;
        if (xfer_req) n_xfer <= n_xfer + 1;
        if (conv_start) begin
            pend <= 1'b1;
            dly  <= LAT;
            pch  <= conv_chan;
            if (n_conv < 256) seq_log[n_conv] <= conv_chan;
            n_conv <= n_conv + 1;
        end else if (pend) begin
            if (dly == 1) begin
                mdl_done     <= 1'b1;
                mdl_res      <= fres(int'(pch), n_conv);
                exp_res[pch] <= fres(int'(pch), n_conv);
                pend         <= 1'b0;
            end else begin
                dly <= dly - 1;
            end
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic run_to_idle();
        int seen = 0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (busy) seen = 1;
            else if (seen != 0) break;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic check_results(string req, int lo, int hi);
        for (int c = lo; c <= hi; c++) begin
            rd_chan = 4'(c);
            #1;
            check(req, 32'(rd_data), {20'd0, 4'd0, exp_res[c]});
        end
    endtask

    task automatic t_reset();
        check("R1 busy", 32'(busy), 0);
        check("R1 conv_start", 32'(conv_start), 0);
        check("R1 eoc_irq", 32'(eoc_irq), 0);
        check("R1 xfer_req", 32'(xfer_req), 0);
        for (int c = 0; c < 16; c++) begin
            rd_chan = 4'(c);
            #1;
            check("R1 result zero", 32'(rd_data), 0);
        end
    endtask

    task automatic t_single(int ch, logic [1:0] m);
        int b = n_conv;
        int bi = n_irq;
        int bx = n_xfer;
        @(negedge clk);
        cfg_mode = m; cfg_src = 0; cfg_chan = 4'(ch);
        start_bit = 1;
        run_to_idle();
        start_bit = 0;
        check("R3 count", 32'(n_conv - b), 1);
        check("R3 channel", 32'(seq_log[b]), 32'(ch));
        check("R9 irq", 32'(n_irq - bi), 1);
        check("R9 xfer", 32'(n_xfer - bx), 1);
        check_results("R2 stored", ch, ch);
    endtask

    task automatic t_multi(int ch, logic g8);
        int base = g8 ? (ch & ~7) : (ch & ~3);
        int b = n_conv;
        int bi = n_irq;
        @(negedge clk);
        cfg_mode = 1; cfg_src = 0; cfg_chan = 4'(ch); cfg_grp8 = g8;
        start_bit = 1;
        run_to_idle();
        start_bit = 0;
        check("R4 count", 32'(n_conv - b), 32'(ch - base + 1));
        for (int i = 0; i <= ch - base; i++)
            check("R4 order", 32'(seq_log[b + i]), 32'(base + i));
        check("R9 irq once", 32'(n_irq - bi), 1);
        check_results("R2 group", base, ch);
    endtask

    task automatic t_scan(int ch, logic g8, int stop_at);
        int base = g8 ? (ch & ~7) : (ch & ~3);
        int plen = ch - base + 1;
        int b = n_conv;
        int bi = n_irq;
        @(negedge clk);
        cfg_mode = 2; cfg_src = 0; cfg_chan = 4'(ch); cfg_grp8 = g8;
        start_bit = 1;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (n_conv - b >= stop_at) break;
        end
        start_bit = 0;
        run_to_idle();
        check("R6 stop count", 32'(n_conv - b), 32'(stop_at));
        for (int i = 0; i < stop_at; i++)
            check("R5 pass order", 32'(seq_log[b + i]), 32'(base + (i % plen)));
        check("R5 R6 irq per pass", 32'(n_irq - bi), 32'(stop_at / plen));
        repeat (20) @(negedge clk);
        check("R6 no restart", 32'(n_conv - b), 32'(stop_at));
    endtask

    task automatic t_busy_ignore();
        int b = n_conv;
        int bi = n_irq;
        @(negedge clk);
        cfg_mode = 1; cfg_src = 0; cfg_chan = 4'd7; cfg_grp8 = 1;
        start_bit = 1;
        repeat (4) @(negedge clk);
        start_bit = 0;
        @(negedge clk);
        start_bit = 1;
        tmr_trig = 1;
        @(negedge clk);
        tmr_trig = 0;
        run_to_idle();
        repeat (20) @(negedge clk);
        start_bit = 0;
        check("R8 count", 32'(n_conv - b), 8);
        check("R8 irq", 32'(n_irq - bi), 1);
    endtask

    task automatic t_timer();
        int b = n_conv;
        @(negedge clk);
        cfg_mode = 0; cfg_src = 1; cfg_chan = 4'd9;
        start_bit = 1;
        repeat (10) @(negedge clk);
        start_bit = 0;
        ext_trig_n = 0;
        repeat (3) @(negedge clk);
        ext_trig_n = 1;
        repeat (10) @(negedge clk);
        check("R7 unselected ignored", 32'(n_conv - b), 0);
        tmr_trig = 1;
        @(negedge clk);
        tmr_trig = 0;
        run_to_idle();
        check("R7 timer count", 32'(n_conv - b), 1);
        check("R7 timer channel", 32'(seq_log[b]), 9);
    endtask

    task automatic t_ext();
        int b = n_conv;
        @(negedge clk);
        cfg_mode = 0; cfg_src = 2; cfg_chan = 4'd0;
        tmr_trig = 1;
        @(negedge clk);
        tmr_trig = 0;
        repeat (10) @(negedge clk);
        check("R7 timer ignored", 32'(n_conv - b), 0);
        ext_trig_n = 0;
        run_to_idle();
        check("R7 ext count", 32'(n_conv - b), 1);
        check("R7 ext channel", 32'(seq_log[b]), 0);
        ext_trig_n = 1;
        repeat (10) @(negedge clk);
        check("R7 rising edge ignored", 32'(n_conv - b), 1);
        cfg_src = 0;
    endtask

    task automatic t_stray();
        @(negedge clk);
        stray_res = 12'hABC;
        stray_done = 1;
        @(negedge clk);
        stray_done = 0;
        repeat (2) @(negedge clk);
        check("R10 busy", 32'(busy), 0);
        check_results("R10 unchanged", 0, 15);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1;
        repeat (2) @(negedge clk);
        t_single(5, 2'd0);
        t_single(15, 2'd0);
        t_single(0, 2'd3);
        t_multi(6, 1'b0);
        t_multi(15, 1'b1);
        t_multi(4, 1'b0);
        t_scan(5, 1'b0, 6);
        t_scan(10, 1'b0, 7);
        t_busy_ignore();
        t_timer();
        t_ext();
        t_stray();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule